// File: doc/BRIEF.md
# Selectable Master Clock Sample Divider

This block turns a set of free-running oscillator ticks into the sample strobe that paces an analog converter. Up to four oscillators are present, each as a one-cycle clock-enable input in the system clock domain. A configuration word picks one source slot and a power-of-two divide (1, 2, 4 or 8). The block emits a one-cycle `sample_stb` each time the chosen number of ticks from the chosen source has elapsed. Which source slots are populated is a build parameter: one board variant has four oscillators, another has three with the fourth slot left empty.

Any write that alters the timing field (source plus divide) restarts the divider from zero and raises `timing_changed` for one cycle, so that the trigger logic downstream can hold off for a settling interval. Two power-down bits stop the clocking entirely and hold the divider at zero, so it always resumes in a known phase. After reset, and after every power-down, an offset calibration runs for a fixed number of sample strobes. `cal_busy` stays high while it runs, and the input-enable outputs stay forced low until it ends.

All pins are plain control and status signals. There is no data stream and so no back-pressure. The configuration word is taken whole on any cycle with `cfg_wr` high.

Top module: `smpl_clk_divider`

## Requirements
- R1: While running, `sample_stb` is high for exactly one cycle, in the cycle after the tick of the selected source that completes 2^e ticks since the last strobe or restart, where e is cfg bits 6:5.
- R2: Only the tick input chosen by cfg bits 4:3 (0 to 3) advances the divider; ticks on other inputs have no effect on the strobe.
- R3: When bits 4:3 select a slot whose bit in `SRC_PRESENT` is 0, `sample_stb` stays low whatever the tick inputs do.
- R4: `timing_changed` is high for one cycle, in the cycle after a write whose bits 6:3 differ from the stored bits 6:3.
- R5: A write that changes bits 6:3 clears the divider count, so the next strobe needs a full 2^e ticks counted from the cycle after the write.
- R6: A write that leaves bits 6:3 unchanged raises no `timing_changed` pulse and does not disturb the divider count.
- R7: While cfg bit 11 (analog power-down) or bit 12 (digital power-down) is set, `sample_stb` stays low and the count is held at zero, so counting resumes from zero once both are clear.
- R8: `cal_busy` is high from reset and throughout any power-down; once both power-down bits are clear, it falls after `CAL_STROBES` further sample strobes.
- R9: `inputs_en[1:0]` follows cfg bits 8:7 (bit 7 enables inputs 0 and 1, bit 8 enables inputs 2 and 3) while `cal_busy` is low, and is 00 while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads `cfg_data` into the configuration word |
| cfg_data | input | CFG_W | New configuration word |
| osc_tick | input | NUM_SRC | One-cycle tick from each master oscillator |
| sample_stb | output | 1 | One-cycle sample strobe |
| timing_changed | output | 1 | One-cycle pulse after a timing field change |
| cal_busy | output | 1 | Offset calibration in progress |
| inputs_en | output | 2 | Analog input pair enables |

## Verification
The bench targets the points where the divider phase is easy to get wrong. A restart that does not clear the count fires the next strobe early. A rewrite of the same timing field that restarts anyway fires it late. Power-down that freezes the count instead of zeroing it resumes in a stale phase. It also selects the empty source slot while every tick line is held high, which exposes a mux that leaks another oscillator. It counts calibration strobes across a power-down, which catches a tracker that keeps its old progress or drops out one strobe early.

// File: rtl/smpl_clk_pkg.sv
package smpl_clk_pkg;
  // Field positions in the configuration word; neighbours decode these.
  localparam int SRC_LSB = 3;
  localparam int SRC_W   = 2;
  localparam int EXP_LSB = 5;
  localparam int EXP_W   = 2;
  localparam int TIM_LSB = SRC_LSB;
  localparam int TIM_W   = SRC_W + EXP_W;
  localparam int EN_LSB  = 7;
  localparam int EN_W    = 2;
  localparam int APD_BIT = 11;
  localparam int DPD_BIT = 12;

  typedef struct packed {
    logic [EXP_W-1:0] dexp;
    logic [SRC_W-1:0] src;
  } timing_t;
endpackage

// File: rtl/smpl_timing_ctl.sv
module smpl_timing_ctl
  import smpl_clk_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  output logic [CFG_W-1:0] cfg_q,
  output logic             restart,
  output logic             timing_changed
);
  timing_t new_tim, cur_tim;

  assign new_tim = timing_t'(cfg_data[TIM_LSB +: TIM_W]);
  assign cur_tim = timing_t'(cfg_q[TIM_LSB +: TIM_W]);
  assign restart = cfg_wr && (new_tim != cur_tim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q          <= '0;
      timing_changed <= 1'b0;
    end else begin
      timing_changed <= restart;
      if (cfg_wr) cfg_q <= cfg_data;
    end
  end

  // R4: a pulse only follows a write
  p_pulse_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timing_changed |-> $past(cfg_wr));
  // R4: a pulse only when the stored timing field actually moved
  p_pulse_field_moved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timing_changed |-> (cfg_q[TIM_LSB +: TIM_W] != $past(cfg_q[TIM_LSB +: TIM_W])));
endmodule

// File: rtl/smpl_rate_div.sv
module smpl_rate_div
  import smpl_clk_pkg::*;
#(
  parameter int          NUM_SRC     = 4,
  parameter logic [3:0]  SRC_PRESENT = 4'b0111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] osc_tick,
  input  logic [SRC_W-1:0]   src,
  input  logic [EXP_W-1:0]   dexp,
  input  logic               pwr_down,
  input  logic               restart,
  output logic               sample_stb
);
  localparam int CNT_W = (1 << EXP_W) - 1;
  localparam logic [CNT_W-1:0] ONES = '1;

  logic [NUM_SRC-1:0] tick_gated;
  logic [CNT_W-1:0]   cnt, lim, sh;
  logic               present, run, sel_tick, hit;

  // Empty oscillator slots are tied off at build time.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    if (SRC_PRESENT[g]) begin : g_live
      assign tick_gated[g] = osc_tick[g];
    end else begin : g_empty
      assign tick_gated[g] = 1'b0;
    end
  end

  assign present  = SRC_PRESENT[src];
  assign run      = present && !pwr_down;
  assign sel_tick = tick_gated[src];
  assign sh       = CNT_W'(CNT_W) - CNT_W'(dexp);
  assign lim      = ONES >> sh;
  assign hit      = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      sample_stb <= 1'b0;
    end else if (restart || !run) begin
      cnt        <= '0;
      sample_stb <= 1'b0;
    end else if (sel_tick) begin
      sample_stb <= hit;
      cnt        <= hit ? '0 : cnt + 1'b1;
    end else begin
      sample_stb <= 1'b0;
    end
  end

  // R1: every strobe is caused by a tick of the selected live source
  p_stb_from_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(sel_tick && run));
  // R3: an empty slot never yields a strobe
  p_empty_slot_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !present |=> !sample_stb);
  // R7: power-down keeps the strobe quiet
  p_pwrdn_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !sample_stb);
  // R5: a timing change never strobes on the following cycle
  p_restart_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !sample_stb);
endmodule

// File: rtl/smpl_cal_track.sv
module smpl_cal_track #(
  parameter int CAL_STROBES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic sample_stb,
  output logic cal_busy
);
  localparam int CW = $clog2(CAL_STROBES + 1);
  localparam logic [CW-1:0] LAST = CW'(CAL_STROBES - 1);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_busy <= 1'b1;
      seen     <= '0;
    end else if (pwr_down) begin
      cal_busy <= 1'b1;
      seen     <= '0;
    end else if (cal_busy && sample_stb) begin
      if (seen == LAST) begin
        cal_busy <= 1'b0;
        seen     <= '0;
      end else begin
        seen <= seen + 1'b1;
      end
    end
  end

  // R8: power-down always re-arms calibration
  p_pwrdn_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> cal_busy);
  // R8: calibration only finishes on a strobe
  p_done_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> $past(sample_stb));
endmodule

// File: rtl/smpl_clk_divider.sv
module smpl_clk_divider
  import smpl_clk_pkg::*;
#(
  parameter int         CFG_W       = 16,
  parameter int         NUM_SRC     = 1 << SRC_W,
  parameter logic [3:0] SRC_PRESENT = 4'b0111,
  parameter int         CAL_STROBES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_W-1:0]   cfg_data,
  input  logic [NUM_SRC-1:0] osc_tick,
  output logic               sample_stb,
  output logic               timing_changed,
  output logic               cal_busy,
  output logic [EN_W-1:0]    inputs_en
);
  localparam logic [CFG_W-1:0] USED_MASK =
    CFG_W'(((1 << TIM_W) - 1) << TIM_LSB) |
    CFG_W'(((1 << EN_W) - 1) << EN_LSB) |
    CFG_W'(1 << APD_BIT) | CFG_W'(1 << DPD_BIT);

  logic [CFG_W-1:0] cfg_q;
  logic             restart, pwr_down;
  timing_t          tim;
  logic             unused_cfg;

  assign tim        = timing_t'(cfg_q[TIM_LSB +: TIM_W]);
  assign pwr_down   = cfg_q[APD_BIT] | cfg_q[DPD_BIT];
  assign unused_cfg = ^(cfg_q & ~USED_MASK);

  smpl_timing_ctl #(.CFG_W(CFG_W)) u_tim (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .cfg_q(cfg_q), .restart(restart), .timing_changed(timing_changed)
  );

  smpl_rate_div #(.NUM_SRC(NUM_SRC), .SRC_PRESENT(SRC_PRESENT)) u_div (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .src(tim.src),
    .dexp(tim.dexp), .pwr_down(pwr_down), .restart(restart),
    .sample_stb(sample_stb)
  );

  smpl_cal_track #(.CAL_STROBES(CAL_STROBES)) u_cal (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .sample_stb(sample_stb), .cal_busy(cal_busy)
  );

  assign inputs_en = cal_busy ? '0 : cfg_q[EN_LSB +: EN_W];

  // R9: no input is enabled during calibration, checked across a clock edge
  p_inputs_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_down) |-> (inputs_en == '0));
endmodule

// File: tb/test_smpl_clk_divider.sv
module test_smpl_clk_divider;
  localparam logic [3:0] PRESENT = 4'b0111;
  localparam int CAL = 4;

  logic clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0;
  logic [15:0] cfg_data = '0;
  logic [3:0] osc_tick = '0;
  logic sample_stb, timing_changed, cal_busy;
  logic [1:0] inputs_en;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // bench reference state
  logic [15:0] m_cfg;
  int m_cnt, m_calcnt;
  bit m_stb, m_tc, m_busy;

  always #2 clk = ~clk;

  smpl_clk_divider #(.SRC_PRESENT(PRESENT), .CAL_STROBES(CAL)) i_smpl_clk_divider (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .osc_tick(osc_tick), .sample_stb(sample_stb), .timing_changed(timing_changed),
    .cal_busy(cal_busy), .inputs_en(inputs_en));

  function automatic int lim_of(input logic [1:0] e);
    return (1 << e) - 1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "sample_stb", int'(sample_stb), int'(m_stb));
    chk("R4", "timing_changed", int'(timing_changed), int'(m_tc));
    chk("R8", "cal_busy", int'(cal_busy), int'(m_busy));
    chk("R9", "inputs_en", int'(inputs_en), int'(m_cfg[8:7] & {2{~m_busy}}));
  endtask

  // one clock: drive at negedge, advance the reference, compare at next negedge
  task automatic step(input bit wr, input logic [15:0] d, input logic [3:0] tk);
    logic [1:0] src, e;
    bit pd, run, chg, old_stb;
    cfg_wr = wr; cfg_data = d; osc_tick = tk;
    src = m_cfg[4:3]; e = m_cfg[6:5];
    pd = m_cfg[11] | m_cfg[12];
    run = !pd && PRESENT[src];
    chg = wr && (d[6:3] != m_cfg[6:3]);
    old_stb = m_stb;
    if (pd) begin m_busy = 1; m_calcnt = 0; end
    else if (m_busy && old_stb) begin
      if (m_calcnt == CAL - 1) begin m_busy = 0; m_calcnt = 0; end
      else m_calcnt++;
    end
    if (chg || !run) begin m_cnt = 0; m_stb = 0; end
    else if (tk[src]) begin
      m_stb = (m_cnt == lim_of(e));
      m_cnt = m_stb ? 0 : m_cnt + 1;
    end else m_stb = 0;
    m_tc = chg;
    if (wr) m_cfg = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    compare_all();
  endtask

  task automatic idle(input int n, input logic [3:0] tk);
    for (int i = 0; i < n; i++) step(1'b0, '0, tk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_cfg = '0; m_cnt = 0; m_calcnt = 0; m_stb = 0; m_tc = 0; m_busy = 1;
    repeat (3) @(negedge clk);
    // reset state: quiet strobe, calibration busy, inputs off (R8)
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R6: enable inputs, timing field unchanged (src 0, divide 1)
    cur_req = "R6";
    step(1'b1, 16'h0180, 4'h0);
    // R1 divide by 1 on every tick; R9 inputs come up after CAL strobes
    cur_req = "R1";
    idle(12, 4'h1);
    // R4/R5: divide by 4, restart mid-count
    cur_req = "R5";
    step(1'b1, 16'h01C0, 4'h1);
    idle(2, 4'h1);
    step(1'b1, 16'h01A0, 4'h1);   // divide by 2: change -> restart
    idle(6, 4'h1);
    step(1'b1, 16'h01C0, 4'h1);   // back to divide by 4
    idle(10, 4'h1);
    // R6: rewrite identical timing mid-count, no phase disturbance
    cur_req = "R6";
    idle(2, 4'h1);
    step(1'b1, 16'h00C0, 4'h1);
    idle(6, 4'h1);
    step(1'b1, 16'h01C0, 4'h1);
    // R2: src 1, ticks only on other lines then on line 1
    cur_req = "R2";
    step(1'b1, 16'h01C8, 4'h0);
    idle(10, 4'hD);
    idle(10, 4'h2);
    // R3: empty slot 3 with every tick high
    cur_req = "R3";
    step(1'b1, 16'h0198, 4'hF);
    idle(20, 4'hF);
    // R7/R8: power-down then release, divide by 8 on src 2
    cur_req = "R7";
    step(1'b1, 16'h01F0, 4'h4);
    idle(3, 4'h4);
    step(1'b1, 16'h19F0, 4'h4);
    idle(5, 4'h4);
    step(1'b1, 16'h09F0, 4'h4);
    idle(5, 4'h4);
    step(1'b1, 16'h01F0, 4'h4);
    idle(40, 4'h4);
    // R1 random mix
    cur_req = "R1";
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d;
      bit wr;
      wr = ($urandom % 16) == 0;
      d = 16'($urandom) & 16'h19F8;
      if (($urandom % 4) != 0) d[12:11] = 2'b00;
      step(wr, d, 4'($urandom));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule